// File: doc/BRIEF.md
# Serial Bootstrap RAM Loader

This block fills a fixed window of on-chip RAM with a program that arrives as a plain byte stream from a serial receiver. Each received byte is written to the next address of the window, starting at the window base. There is no length header. The download ends in one of two ways: the line stays quiet for four character times after the last byte, or the byte for the top address of the window is stored. When either happens, the block raises a start request that carries the window base as the entry address. It holds that request until the processor acknowledges it.

The block runs only when the bootstrap operating mode is selected. It samples the mode input once, in the first cycle after reset is released. The character time is programmable: `bit_div_i` gives the clock cycles per bit, and one character is ten bit times.

The controller has five states:
- `ST_SAMPLE`: the first cycle after reset. It moves to `ST_ARMED` if the mode input is high and to `ST_HALT` otherwise.
- `ST_ARMED`: waits with no time limit for the first byte. On a byte it moves to `ST_LOAD`, or to `ST_LAUNCH` if that byte filled the window.
- `ST_LOAD`: accepts bytes and runs the idle timer. It moves to `ST_LAUNCH` on the window-filling byte or when the timer expires.
- `ST_LAUNCH`: drives the start request. It moves to `ST_HALT` on acknowledge.
- `ST_HALT`: ignores everything until the next reset.

Top module: `boot_loader`

## Requirements
- R1: If `boot_mode_i` is low in the first clock cycle after reset release, the block never strobes `ram_we_o` and never raises `start_req_o` until the next reset, whatever bytes arrive.
- R2: Before the first byte of a download is accepted, no timeout runs: `start_req_o` stays low however long the line is quiet.
- R3: Each byte presented with `rx_valid_i` high at a clock edge while loading gives `ram_we_o` high for exactly the following cycle. During that cycle `ram_wdata_o` equals the byte.
- R4: Accepted bytes go to consecutive addresses on `ram_addr_o`. The first goes to 0x0080 and the 768th to 0x037F.
- R5: With no further byte, `start_req_o` rises exactly 40 × `bit_div_i` clock cycles after the edge that accepted the last byte. This is four characters of ten bit times.
- R6: A byte that arrives at the very edge where the timeout would fire is accepted, and the timeout restarts from that byte.
- R7: Accepting the byte for 0x037F ends the download at once. `start_req_o` is high in the same cycle as that byte's write strobe.
- R8: While `start_req_o` is high, `start_addr_o` is 0x0080. The request stays high until `start_ack_i` is seen high at a clock edge, and is low from the next cycle on.
- R9: From the cycle `start_req_o` is first high until the next reset, received bytes cause no write. After the acknowledge, `start_req_o` stays low.
- R10: During reset, `ram_we_o` and `start_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode_i | input | 1 | High selects the bootstrap mode; sampled once after reset |
| rx_valid_i | input | 1 | Received byte strobe, one cycle per byte |
| rx_data_i | input | 8 | Received byte |
| bit_div_i | input | DIV_W (16) | Clock cycles per serial bit time, at least 1 |
| ram_we_o | output | 1 | RAM write strobe |
| ram_addr_o | output | ADDR_W (16) | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |
| start_req_o | output | 1 | Request to start execution |
| start_addr_o | output | ADDR_W (16) | Entry address for the start request |
| start_ack_i | input | 1 | Acknowledge of the start request |

## Verification
The assertions check, on every cycle:
- every write lands inside the window;
- the first write goes to the base, and each later write goes to the address after the one before;
- each strobe carries the byte presented one cycle earlier;
- the top-address write coincides with the start request;
- the request holds until acknowledged;
- the block stays silent both after the handshake and after a non-bootstrap mode sample.

Only the bench scenarios can show the exact timeout distance in cycles, that a byte at the expiry edge wins, that an unlimited wait before the first byte never times out, and the entry address value.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [2:0] {
        ST_SAMPLE = 3'd0,
        ST_ARMED  = 3'd1,
        ST_LOAD   = 3'd2,
        ST_LAUNCH = 3'd3,
        ST_HALT   = 3'd4
    } boot_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/boot_idle_timer.sv
module boot_idle_timer #(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned IDLE_BITS = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [DIV_W-1:0] bit_div_i,
    output logic             expire_o
);
    localparam int unsigned BC_W = $clog2(IDLE_BITS + 1);

    logic [DIV_W-1:0] cyc_q;
    logic [BC_W-1:0]  bit_q;
    logic             bit_end;
    logic             last_bit;

    // one bit time has elapsed when the prescaler reaches divisor-1
    assign bit_end  = (cyc_q == (bit_div_i - DIV_W'(1)));
    assign last_bit = (bit_q == BC_W'(IDLE_BITS - 1));
    assign expire_o = run_i && bit_end && last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            bit_q <= '0;
        end else if (clear_i || !run_i) begin
            cyc_q <= '0;
            bit_q <= '0;
        end else if (bit_end) begin
            cyc_q <= '0;
            bit_q <= bit_q + BC_W'(1);
        end else begin
            cyc_q <= cyc_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/boot_wr_port.sv
module boot_wr_port
    import boot_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]    WIN_BASE = 16'h0080,
    parameter logic [ADDR_W-1:0]    WIN_LAST = 16'h037F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              last_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [BYTE_W-1:0] ram_wdata_o
);
    logic [ADDR_W-1:0] ptr_q;

    // the pointer names the slot the next accepted byte will fill
    assign last_o = (ptr_q == WIN_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q       <= WIN_BASE;
            ram_we_o    <= 1'b0;
            ram_addr_o  <= WIN_BASE;
            ram_wdata_o <= '0;
        end else begin
            ram_we_o <= accept_i;
            if (accept_i) begin
                ram_addr_o  <= ptr_q;
                ram_wdata_o <= data_i;
                ptr_q       <= ptr_q + ADDR_W'(1);
            end
        end
    end

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_mode_i,
    input  logic rx_valid_i,
    input  logic last_i,
    input  logic expire_i,
    input  logic start_ack_i,
    output logic accept_o,
    output logic timer_run_o,
    output logic start_req_o
);
    boot_state_e state_q;
    boot_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic; a received byte outranks the idle timeout
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SAMPLE: state_d = boot_mode_i ? ST_ARMED : ST_HALT;
            ST_ARMED: begin
                if (rx_valid_i) begin
                    state_d = last_i ? ST_LAUNCH : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (rx_valid_i) begin
                    if (last_i) begin
                        state_d = ST_LAUNCH;
                    end
                end else if (expire_i) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                if (start_ack_i) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        accept_o    = 1'b0;
        timer_run_o = 1'b0;
        start_req_o = 1'b0;
        unique case (state_q)
            ST_SAMPLE: ;
            ST_ARMED:  accept_o = rx_valid_i;
            ST_LOAD: begin
                accept_o    = rx_valid_i;
                timer_run_o = 1'b1;
            end
            ST_LAUNCH: start_req_o = 1'b1;
            ST_HALT:   ;
            default:   ;
        endcase
    end

endmodule

// File: rtl/boot_loader.sv
module boot_loader
    import boot_pkg::*;
#(
    parameter int unsigned       ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE      = 16'h0080,
    parameter int unsigned       WIN_BYTES     = 768,
    parameter int unsigned       DIV_W         = 16,
    parameter int unsigned       BITS_PER_CHAR = 10,
    parameter int unsigned       IDLE_CHARS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    input  logic [DIV_W-1:0]  bit_div_i,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [7:0]        ram_wdata_o,
    output logic              start_req_o,
    output logic [ADDR_W-1:0] start_addr_o,
    input  logic              start_ack_i
);
    localparam logic [ADDR_W-1:0] WIN_LAST  = ADDR_W'(WIN_BASE + WIN_BYTES - 1);
    localparam int unsigned       IDLE_BITS = BITS_PER_CHAR * IDLE_CHARS;

    logic accept;
    logic timer_run;
    logic expire;
    logic last_slot;

    assign start_addr_o = WIN_BASE;

    boot_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode_i (boot_mode_i),
        .rx_valid_i  (rx_valid_i),
        .last_i      (last_slot),
        .expire_i    (expire),
        .start_ack_i (start_ack_i),
        .accept_o    (accept),
        .timer_run_o (timer_run),
        .start_req_o (start_req_o)
    );

    boot_idle_timer #(
        .DIV_W     (DIV_W),
        .IDLE_BITS (IDLE_BITS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (timer_run),
        .clear_i   (accept),
        .bit_div_i (bit_div_i),
        .expire_o  (expire)
    );

    boot_wr_port #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LAST (WIN_LAST)
    ) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .data_i      (rx_data_i),
        .last_o      (last_slot),
        .ram_we_o    (ram_we_o),
        .ram_addr_o  (ram_addr_o),
        .ram_wdata_o (ram_wdata_o)
    );

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
    parameter int unsigned       ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h0080,
    parameter int unsigned       WIN_BYTES = 768
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boot_mode_i,
    input logic              rx_valid_i,
    input logic [7:0]        rx_data_i,
    input logic              ram_we_o,
    input logic [ADDR_W-1:0] ram_addr_o,
    input logic [7:0]        ram_wdata_o,
    input logic              start_req_o,
    input logic              start_ack_i
);
    localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(WIN_BASE + WIN_BYTES - 1);

    logic              first_q;
    logic              mode_q;
    logic              done_q;
    logic              have_prev_q;
    logic [ADDR_W-1:0] prev_addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q     <= 1'b1;
            mode_q      <= 1'b1;
            done_q      <= 1'b0;
            have_prev_q <= 1'b0;
            prev_addr_q <= '0;
        end else begin
            first_q <= 1'b0;
            if (first_q) begin
                mode_q <= boot_mode_i;
            end
            if (start_req_o && start_ack_i) begin
                done_q <= 1'b1;
            end
            if (ram_we_o) begin
                have_prev_q <= 1'b1;
                prev_addr_q <= ram_addr_o;
            end
        end
    end

    p_inert_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_q && !mode_q) |-> (!ram_we_o && !start_req_o));

    p_src_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> ($past(rx_valid_i) && ram_wdata_o == $past(rx_data_i)));

    p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o >= WIN_BASE && ram_addr_o <= WIN_LAST));

    p_first_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o && !have_prev_q) |-> (ram_addr_o == WIN_BASE));

    p_consec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o && have_prev_q) |-> (ram_addr_o == prev_addr_q + ADDR_W'(1)));

    p_top_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o && ram_addr_o == WIN_LAST) |-> start_req_o);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req_o && !start_ack_i) |=> start_req_o);

    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!ram_we_o && !start_req_o));

endmodule

bind boot_loader boot_loader_chk #(
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .WIN_BYTES (WIN_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_mode_i (boot_mode_i),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .start_req_o (start_req_o),
    .start_ack_i (start_ack_i)
);

// File: tb/boot_loader_tb.sv
module boot_loader_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int          DIV  = 3;
    localparam int          IDLE = 40 * DIV;
    localparam logic [15:0] BASE = 16'h0080;
    localparam logic [15:0] TOP  = 16'h037F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_mode = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        start_ack = 1'b0;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        start_req;
    logic [15:0] start_addr;

    int          n_chk = 0;
    int          n_bad = 0;
    string       cur_req = "R10";
    logic [23:0] expq[$];
    logic [15:0] wr_ptr = BASE;
    int unsigned cyc = 0;
    int unsigned last_we_cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    boot_loader u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .boot_mode_i  (boot_mode),
        .rx_valid_i   (rx_valid),
        .rx_data_i    (rx_data),
        .bit_div_i    (16'(DIV)),
        .ram_we_o     (ram_we),
        .ram_addr_o   (ram_addr),
        .ram_wdata_o  (ram_wdata),
        .start_req_o  (start_req),
        .start_addr_o (start_addr),
        .start_ack_i  (start_ack)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: every write strobe is compared against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n === 1'b1 && ram_we === 1'b1) begin
            last_we_cyc = cyc;
            if (expq.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL %s: actual write 0x%0h<=0x%0h expected no write",
                         cur_req, ram_addr, ram_wdata);
            end else begin
                check_eq({cur_req, " write"}, {8'h0, ram_addr, ram_wdata}, {8'h0, expq.pop_front()});
            end
        end
    end

    task automatic do_reset(input logic mode);
        rst_n     = 1'b0;
        boot_mode = mode;
        rx_valid  = 1'b0;
        start_ack = 1'b0;
        wr_ptr    = BASE;
        repeat (3) @(negedge clk);
        check_eq("R10 reset we", 32'(ram_we), 32'h0);
        check_eq("R10 reset req", 32'(start_req), 32'h0);
        rst_n = 1'b1;
    endtask

    // driver: presents one byte for one cycle and queues the write it expects
    task automatic send(input logic [7:0] d, input bit exp_wr);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = d;
        if (exp_wr) begin
            expq.push_back({wr_ptr, d});
            wr_ptr = wr_ptr + 16'd1;
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_req();
        for (int g = 0; g < 1000 && start_req !== 1'b1; g++) begin
            @(negedge clk);
        end
    endtask

    initial begin
        #(5ns * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // scenario A: not in bootstrap mode, the block stays inert (R1)
        do_reset(1'b0);
        cur_req = "R1";
        @(negedge clk);
        send(8'h11, 1'b0);
        send(8'h22, 1'b0);
        send(8'h33, 1'b0);
        repeat (200) @(negedge clk);
        check_eq("R1 no start", 32'(start_req), 32'h0);

        // scenario B: timeout-terminated download
        do_reset(1'b1);
        cur_req = "R2";
        repeat (300) @(negedge clk);
        check_eq("R2 no timeout before first byte", 32'(start_req), 32'h0);
        cur_req = "R3";
        send(8'hA5, 1'b1);
        @(negedge clk);
        check_eq("R3 strobe one cycle", 32'(ram_we), 32'h0);
        send(8'h3C, 1'b1);
        repeat (5) @(negedge clk);
        send(8'hFF, 1'b1);
        send(8'h00, 1'b1);
        repeat (17) @(negedge clk);
        send(8'h5E, 1'b1);
        // R6: next byte lands on the exact edge the timeout would fire
        cur_req = "R6";
        repeat (IDLE - 2) @(negedge clk);
        check_eq("R6 no start before edge", 32'(start_req), 32'h0);
        send(8'h99, 1'b1);
        check_eq("R6 late byte written", 32'(ram_we), 32'h1);
        check_eq("R6 no start yet", 32'(start_req), 32'h0);
        cur_req = "R5";
        wait_req();
        check_eq("R5 timeout distance", cyc - last_we_cyc, 32'(IDLE));
        check_eq("R8 entry address", 32'(start_addr), 32'(BASE));
        cur_req = "R9";
        send(8'h77, 1'b0);
        repeat (8) @(negedge clk);
        check_eq("R8 held without ack", 32'(start_req), 32'h1);
        start_ack = 1'b1;
        @(negedge clk);
        start_ack = 1'b0;
        check_eq("R8 drop after ack", 32'(start_req), 32'h0);
        send(8'h01, 1'b0);
        send(8'h02, 1'b0);
        repeat (200) @(negedge clk);
        check_eq("R9 no new start", 32'(start_req), 32'h0);

        // scenario C: window-full download
        do_reset(1'b1);
        cur_req = "R4";
        for (int i = 0; i < 768; i++) begin
            send(8'(i) ^ 8'h5A, 1'b1);
            if (i < 767) begin
                check_eq("R7 no early start", 32'(start_req), 32'h0);
            end
        end
        check_eq("R7 start with last strobe", 32'(start_req), 32'h1);
        check_eq("R4 last address", 32'(ram_addr), 32'(TOP));
        cur_req = "R9";
        send(8'hEE, 1'b0);
        check_eq("R8 entry address full", 32'(start_addr), 32'(BASE));
        start_ack = 1'b1;
        @(negedge clk);
        start_ack = 1'b0;
        check_eq("R8 drop after ack full", 32'(start_req), 32'h0);
        repeat (10) @(negedge clk);
        check_eq("R4 all writes seen", 32'(expq.size()), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule